// File: doc/BRIEF.md
# Round-Robin Interleaved Multiplier Datapath

This block accepts one unsigned operand pair on every clock cycle and deals the pairs out, in strict rotation, to a set of identical multiplier copies. Every copy owns an operand register that is loaded only when its phase is active. The copy's combinational product is therefore stable for a whole rotation, so each multiplier is a multicycle path with as many cycles as there are copies. The whole block runs on one clock. A one-hot ring of phase enables both loads the operand registers and steers a many-to-one selector, and the selector feeds an output register that updates every cycle.

A valid flag runs beside the data through a shift register whose length matches the data latency. Results leave the block in the same order the operands entered, at full rate. Use it where a wide product must keep up with a fast sample stream while each multiplier copy is timed against a clock several times slower.

Top module: `ilm_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `phase` equal to 1 (bit 0 set, all other bits clear), `out_valid` low and `out_prod` zero.
- R2: Out of reset, exactly one bit of `phase` is set in every cycle.
- R3: The set bit of `phase` moves from bit k to bit k+1 on each rising edge, and from bit N-1 back to bit 0.
- R4: When `out_valid` is high, `out_prod` equals the full 2W-bit unsigned product of the `in_a` and `in_b` sampled N+1 rising edges earlier.
- R5: `out_valid` equals the `in_valid` sampled N+1 rising edges earlier, once N+1 edges have passed since reset.
- R6: Back-to-back valid samples produce one result per cycle, in input order, with no gaps.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low N+1 cycles later, and it does not disturb the results of the valid samples around it.
- R8: All-ones operands give the all-ones-squared product (0xFFFE0001 for W = 16) with no truncation.
- R9: A reset in the middle of a stream drops every pending result, so `out_valid` stays low until new valid samples have travelled the full N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is a real sample |
| in_a | input | W | Unsigned multiplicand |
| in_b | input | W | Unsigned multiplier |
| out_valid | output | 1 | `out_prod` carries a result |
| out_prod | output | 2*W | Registered unsigned product |
| phase | output | N | One-hot phase: bit k set means copy k loads this cycle |

## Verification
The data and latency properties count rising edges since reset and stay silent until N+1 of them have passed. They therefore assume that no sample presented while reset was high, or before the first edge, is ever expected at the output. The bench keeps to this: it holds `in_valid` low during every reset and starts comparing results only against samples it drove after reset went low. The operands are assumed to be known values on every edge, including cycles with `in_valid` low, because the copies load on their phase whatever the valid flag is. The bench therefore drives defined operands on every cycle, idle cycles included.

// File: rtl/ilm_pkg.sv
package ilm_pkg;

    // Default operand width and number of multiplier copies.
    localparam int unsigned DEF_W = 16;
    localparam int unsigned DEF_N = 5;

    // Width of a binary index into N copies (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter that must reach n.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ilm_phase_ring.sv
module ilm_phase_ring
    import ilm_pkg::*;
#(
    parameter int unsigned N  = DEF_N,
    localparam int unsigned IW = idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [N-1:0]  ring,
    output logic [IW-1:0] sel
);

    logic [N-1:0] ring_q;
    logic [N-1:0] ring_nx;

    generate
        if (N > 1) begin : g_rot
            assign ring_nx = {ring_q[N-2:0], ring_q[N-1]};
        end else begin : g_single
            assign ring_nx = ring_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q <= N'(1);
        end else begin
            ring_q <= ring_nx;
        end
    end

    // Binary index of the active phase, used to steer the output selector.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (ring_q[i]) begin
                sel = IW'(i);
            end
        end
    end

    assign ring = ring_q;

endmodule

// File: rtl/ilm_lane.sv
module ilm_lane
    import ilm_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    localparam int unsigned PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic [PW-1:0] prod
);

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;

    // Operands are held for a full rotation; the product below is a
    // multicycle path with N cycles to settle.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= opa;
            b_q <= opb;
        end
    end

    assign prod = PW'(a_q) * PW'(b_q);

endmodule

// File: rtl/ilm_out_sel.sv
module ilm_out_sel
    import ilm_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    parameter int unsigned N = DEF_N,
    localparam int unsigned PW = 2 * W,
    localparam int unsigned IW = idx_bits(N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0][PW-1:0]  lane_prod,
    input  logic [IW-1:0]         sel,
    output logic [PW-1:0]         prod_q
);

    logic [PW-1:0] picked;

    // The active phase names the copy that is about to be reloaded; its
    // product has had the full rotation to settle.
    always_comb begin
        picked = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == IW'(i)) begin
                picked = lane_prod[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q <= picked;
        end
    end

endmodule

// File: rtl/ilm_valid_pipe.sv
module ilm_valid_pipe
    import ilm_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_N + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr <= {sr[DEPTH-2:0], vin};
                end
            end
        end else begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr <= vin;
                end
            end
        end
    endgenerate

    assign vout = sr[DEPTH-1];

endmodule

// File: rtl/ilm_top.sv
module ilm_top
    import ilm_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    parameter int unsigned N = DEF_N,
    localparam int unsigned PW = 2 * W,
    localparam int unsigned IW = idx_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    output logic          out_valid,
    output logic [PW-1:0] out_prod,
    output logic [N-1:0]  phase
);

    logic [N-1:0]          ring;
    logic [IW-1:0]         sel;
    logic [N-1:0][PW-1:0]  lane_prod;

    ilm_phase_ring #(.N(N)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .ring (ring),
        .sel  (sel)
    );

    generate
        for (genvar k = 0; k < N; k++) begin : g_lane
            ilm_lane #(.W(W)) u_lane (
                .clk  (clk),
                .rst  (rst),
                .load (ring[k]),
                .opa  (in_a),
                .opb  (in_b),
                .prod (lane_prod[k])
            );
        end
    endgenerate

    ilm_out_sel #(.W(W), .N(N)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .lane_prod (lane_prod),
        .sel       (sel),
        .prod_q    (out_prod)
    );

    ilm_valid_pipe #(.DEPTH(N + 1)) u_vpipe (
        .clk  (clk),
        .rst  (rst),
        .vin  (in_valid),
        .vout (out_valid)
    );

    assign phase = ring;

endmodule

// File: rtl/ilm_top_chk.sv
module ilm_top_chk
    import ilm_pkg::*;
#(
    parameter int unsigned W = DEF_W,
    parameter int unsigned N = DEF_N,
    localparam int unsigned PW = 2 * W,
    localparam int unsigned LAT = N + 1,
    localparam int unsigned CW = cnt_bits(LAT)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [W-1:0]  in_a,
    input logic [W-1:0]  in_b,
    input logic          out_valid,
    input logic [PW-1:0] out_prod,
    input logic [N-1:0]  phase
);

    logic [CW-1:0] since_rst;
    logic [N-1:0]  phase_rot;
    logic [PW-1:0] ref_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != CW'(LAT)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    generate
        if (N > 1) begin : g_rot
            assign phase_rot = {phase[N-2:0], phase[N-1]};
        end else begin : g_single
            assign phase_rot = phase;
        end
    endgenerate

    assign ref_prod = PW'(in_a) * PW'(in_b);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (phase == N'(1) && !out_valid && out_prod == '0));

    assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    assert_phase_rotate_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase == $past(phase_rot));

    assert_product_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(LAT) && out_valid) |-> out_prod == $past(ref_prod, LAT));

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        since_rst == CW'(LAT) |-> out_valid == $past(in_valid, LAT));

    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        since_rst != CW'(LAT) |-> !out_valid);

endmodule

bind ilm_top ilm_top_chk #(.W(W), .N(N)) u_chk (.*);

// File: tb/test_ilm_top.sv
module test_ilm_top;

    localparam int unsigned W  = 16;
    localparam int unsigned N  = 5;
    localparam int unsigned PW = 2 * W;
    localparam int unsigned NV = 12;

    // Stimulus table: {a, b}; expected products are formed in the bench.
    localparam logic [2*W-1:0] VEC [NV] = '{
        {16'd3,     16'd7},
        {16'd0,     16'd1234},
        {16'd1,     16'hFFFF},
        {16'hFFFF,  16'hFFFF},
        {16'd256,   16'd256},
        {16'h8000,  16'd2},
        {16'd12345, 16'd54321},
        {16'hAAAA,  16'h5555},
        {16'd17,    16'd0},
        {16'd1000,  16'd1000},
        {16'h7FFF,  16'h8001},
        {16'd99,    16'd101}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic          out_valid;
    logic [PW-1:0] out_prod;
    logic [N-1:0]  phase;

    int checks = 0;
    int errors = 0;
    int ph_idx = 0;
    logic          dl_v [N+1];
    logic [PW-1:0] dl_p [N+1];
    string         tag = "R4";

    always #10 clk = ~clk;

    ilm_top #(.W(W), .N(N)) i_ilm_top (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod),
        .phase     (phase)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i <= N; i++) begin
            dl_v[i] = 1'b0;
            dl_p[i] = '0;
        end
        ph_idx = 0;
    endtask

    // Called just after a falling edge: check this cycle, drive, advance.
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        check("R2", 64'($countones(phase)), 64'd1);
        check("R3", 64'(phase), 64'(N'(1) << ph_idx));
        check("R5", 64'(out_valid), 64'(dl_v[N]));
        if (dl_v[N]) begin
            check(tag, 64'(out_prod), 64'(dl_p[N]));
        end
        in_valid = v;
        in_a = a;
        in_b = b;
        for (int i = N; i > 0; i--) begin
            dl_v[i] = dl_v[i-1];
            dl_p[i] = dl_p[i-1];
        end
        dl_v[0] = v;
        dl_p[0] = PW'(a) * PW'(b);
        ph_idx = (ph_idx + 1) % N;
        @(negedge clk);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state held by reset
        check("R1", 64'(phase), 64'd1);
        check("R1", 64'(out_valid), 64'd0);
        check("R1", 64'(out_prod), 64'd0);
        rst = 1'b0;
        clear_model();
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        @(negedge clk);
        do_reset();

        // R4 R6: table walked back-to-back, results checked in order
        tag = "R4/R6";
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < NV; i++) begin
                step(1'b1, VEC[i][2*W-1:W], VEC[i][W-1:0]);
            end
        end
        for (int i = 0; i <= N + 1; i++) step(1'b0, 16'h1111, 16'h2222);

        // R8: all-ones operands, explicit product
        tag = "R8";
        step(1'b1, 16'hFFFF, 16'hFFFF);
        for (int i = 0; i < N; i++) step(1'b0, 16'h0, 16'h0);
        check("R8", 64'(out_valid), 64'd1);
        check("R8", 64'(out_prod), 64'h0000_0000_FFFE_0001);
        step(1'b0, 16'h0, 16'h0);

        // R7: valid gaps interleaved with samples
        tag = "R7";
        for (int i = 0; i < 4 * N; i++) begin
            step((i % 3) != 1, 16'(i * 37 + 5), 16'(i * 91 + 3));
        end
        for (int i = 0; i <= N + 1; i++) step(1'b0, 16'hBEEF, 16'hCAFE);

        // R9: reset mid-stream drops pending results
        tag = "R9";
        for (int i = 0; i < N; i++) step(1'b1, 16'(i + 1), 16'(i + 2));
        do_reset();
        for (int i = 0; i < N + 2; i++) begin
            check("R9", 64'(out_valid), 64'd0);
            step(1'b0, 16'h0, 16'h0);
        end
        tag = "R9/R4";
        for (int i = 0; i < N + 3; i++) step(1'b1, 16'(i + 40), 16'(i + 60));
        for (int i = 0; i <= N + 1; i++) step(1'b0, 16'h0, 16'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule